// File: doc/BRIEF.md
# Descriptor DMA Command Sequencer

This block is the control engine of one DMA channel. Software places a chain of 16-byte command descriptors in memory, loads the channel's command pointer and sets it running. The sequencer reads the descriptor at the pointer one 32-bit word at a time and decodes its opcode. It then hands a data transfer to an attached peripheral data mover, moves a 1-, 2- or 4-byte word between memory and the descriptor, does nothing (no-op), or halts. When a command finishes, the sequencer writes completion status (and the residual count, for transfers) back into the descriptor. It may then raise an interrupt and either steps to the next descriptor or branches.

The wait, interrupt and branch decisions each take a 2-bit select field from the command and a one-bit result from a separate condition evaluator. The evaluator works on the device status bits the sequencer publishes. Descriptor words are little-endian. Word 0 holds the request count in bits 15:0 and the command in bits 31:16. Word 1 is the data address. Word 2 is the command-dependent word. Word 3 holds the residual count in bits 15:0 and the transfer status in bits 31:16.

States: `S_IDLE`, `S_FETCH`, `S_DECODE`, `S_XFER`, `S_WORD`, `S_DONE`, `S_WB_DEP`, `S_WB_STAT`, `S_NEXT`. The transitions are:

- `S_IDLE`→`S_FETCH` when run and active are both set.
- `S_FETCH`→`S_DECODE` after the fourth word is acknowledged.
- `S_DECODE`→`S_IDLE` on stop or kill.
- `S_DECODE`→`S_DONE` on no-op.
- `S_DECODE`→`S_XFER` for a transfer.
- `S_DECODE`→`S_WORD` for a word access.
- `S_XFER`→`S_DONE` on mover done.
- `S_WORD`→`S_DONE` on memory acknowledge.
- `S_DONE`→`S_IDLE` when the wait condition holds.
- `S_DONE`→`S_WB_DEP` for a load.
- `S_DONE`→`S_WB_STAT` otherwise.
- `S_WB_DEP`→`S_WB_STAT` on acknowledge.
- `S_WB_STAT`→`S_NEXT` on acknowledge.
- `S_NEXT`→`S_IDLE`.

Top module: `dsq_sequencer`

## Requirements
- R1: A descriptor is fetched as four 32-bit reads at pointer +0, +4, +8 and +12 (byte enables 1111), only when run and active are both set. The wake status bit is cleared as the fetch begins.
- R2: Command bits 15:12 carry the opcode: 0 output-more, 1 output-last, 2 input-more, 3 input-last, 4 store-word, 5 load-word, 6 no-op, 7 stop. Bits 10:8 carry the key. Opcodes 8 to 15 kill the channel.
- R3: A transfer whose data address is zero or whose key is 4 or more kills the channel, and so does a word access with a key of 4 or more. A kill sets dead, clears active, pulses irq_o once and leaves the pointer unchanged.
- R4: A transfer drives xfer_req_o with the direction (xfer_out_o=1 for output opcodes), the address, the request count and the last flag, and holds it until xfer_done_i. The value on xfer_resid_i is kept as the residual.
- R5: On completion, word 3 of the descriptor is written at pointer+12 with the current status in bits 31:16. For transfers the residual also goes in bits 15:0 (byte enables 1111); for other commands the byte enables are 1100. A load-word also writes the command-dependent word back at pointer+8.
- R6: After write-back, the flush status bit is cleared if the command was output-last, input-last or a word access. Output-more, input-more and no-op leave it unchanged.
- R7: For word accesses only request-count bits 2:0 count. If bit 2 is set, the access is 4 bytes at the address with bits 1:0 cleared. Otherwise, if bit 1 is set, it is 2 bytes at the address with bit 0 cleared. Otherwise it is 1 byte at the address. Byte lane i is byte address+i.
- R8: Load-word copies the accessed bytes into the low bytes of the command-dependent word and keeps the rest. Store-word writes the low bytes of that word to memory. Both always step sequentially and never branch.
- R9: Branch select is command bits 3:2: 0 never, 1 when cond_br_i is 1, 2 when cond_br_i is 0, 3 always. A sequential step adds 16 to the pointer and clears the branch-taken bit. A branch loads the command-dependent word with bits 3:0 cleared and sets branch-taken.
- R10: Interrupt select is command bits 5:4, with the same coding applied to cond_irq_i. When it holds at completion, irq_o pulses for one cycle.
- R11: Wait select is command bits 1:0, with the same coding applied to cond_wait_i. When it holds at completion, write-back, interrupt and pointer update are all skipped, and the same descriptor is fetched and run again.
- R12: Stop clears active and leaves the pointer unchanged. No-op performs write-back, the conditional interrupt and the conditional branch.
- R13: start_i, with run_i high and the channel neither active nor dead, loads the pointer (bits 3:0 cleared) and sets active; otherwise it is ignored. run_i low clears active and dead. wake_i with run_i high sets wake, and also sets active if the channel is not dead. flush_i sets flush.
- R14: stat_o bits: 3:0 dev_stat_i, 6 branch-taken, 7 active, 8 dead, 9 wake, 10 flush, 11 run; all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel run enable |
| start_i | input | 1 | Load pointer and activate |
| start_ptr_i | input | ADDR_W | Pointer loaded by start_i |
| wake_i | input | 1 | Wake request |
| flush_i | input | 1 | Flush request, sets the flush bit |
| dev_stat_i | input | 4 | Device status bits shown in stat_o |
| cond_wait_i | input | 1 | Evaluator result for the wait select |
| cond_irq_i | input | 1 | Evaluator result for the interrupt select |
| cond_br_i | input | 1 | Evaluator result for the branch select |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | 4 | Byte enables, lane i = address+i |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| mem_ack_i | input | 1 | Memory acknowledge |
| xfer_req_o | output | 1 | Transfer request to the data mover |
| xfer_out_o | output | 1 | 1 = memory to device |
| xfer_last_o | output | 1 | Last transfer of a block |
| xfer_addr_o | output | ADDR_W | Transfer buffer address |
| xfer_len_o | output | 16 | Requested byte count |
| xfer_done_i | input | 1 | Transfer finished |
| xfer_resid_i | input | 16 | Residual count from the mover |
| irq_o | output | 1 | Interrupt pulse |
| stat_o | output | 16 | Channel status |
| cmd_ptr_o | output | ADDR_W | Command pointer |

## Verification
The branch and interrupt selects are each swept over all four codes, with the evaluator result at both values. The final pointer and branch-taken bit separate never, if-true, if-false and always. Load-word is run with all eight low request-count values against one unaligned address, and the data merged into the written-back word shows the chosen size, the alignment and which upper bytes were kept. The transfers use both directions and both last flags to show the residual write-back and when flush clears. A held wait condition, the illegal addresses, keys and opcodes, wake and a start while active cover retry, kill and the ignored inputs.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_XFER,
        S_WORD,
        S_DONE,
        S_WB_DEP,
        S_WB_STAT,
        S_NEXT
    } dsq_state_e;

    localparam logic [3:0] OP_OUT_MORE = 4'd0;
    localparam logic [3:0] OP_OUT_LAST = 4'd1;
    localparam logic [3:0] OP_IN_MORE  = 4'd2;
    localparam logic [3:0] OP_IN_LAST  = 4'd3;
    localparam logic [3:0] OP_STORE_W  = 4'd4;
    localparam logic [3:0] OP_LOAD_W   = 4'd5;
    localparam logic [3:0] OP_NOP      = 4'd6;
    localparam logic [3:0] OP_STOP     = 4'd7;

    localparam int ST_BT    = 6;
    localparam int ST_ACT   = 7;
    localparam int ST_DEAD  = 8;
    localparam int ST_WAKE  = 9;
    localparam int ST_FLUSH = 10;
    localparam int ST_RUN   = 11;

    localparam int DESC_BYTES = 16;
    localparam int KEY_LIMIT  = 4;

endpackage

// File: rtl/dsq_cond_sel.sv
module dsq_cond_sel (
    input  logic [1:0] sel_i,
    input  logic       cond_i,
    output logic       hit_o
);
    always_comb begin
        unique case (sel_i)
            2'd0: hit_o = 1'b0;
            2'd1: hit_o = cond_i;
            2'd2: hit_o = ~cond_i;
            2'd3: hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsq_word_size.sv
module dsq_word_size #(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        cnt_lo_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [3:0]        be_o
);
    always_comb begin
        if (cnt_lo_i[2]) begin
            be_o   = 4'b1111;
            addr_o = {addr_i[ADDR_W-1:2], 2'b00};
        end else if (cnt_lo_i[1]) begin
            be_o   = 4'b0011;
            addr_o = {addr_i[ADDR_W-1:1], 1'b0};
        end else begin
            be_o   = 4'b0001;
            addr_o = addr_i;
        end
    end
endmodule

// File: rtl/dsq_status.sv
module dsq_status
    import dsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       start_i,
    input  logic       wake_i,
    input  logic       flush_i,
    input  logic [3:0] dev_stat_i,
    input  logic       kill_i,
    input  logic       stop_i,
    input  logic       wake_clr_i,
    input  logic       flush_clr_i,
    input  logic       bt_set_i,
    input  logic       bt_clr_i,
    output logic       start_take_o,
    output logic [15:0] stat_o
);
    logic active_q, dead_q, wake_q, flush_q, bt_q;

    assign start_take_o = start_i & run_i & ~active_q & ~dead_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            dead_q   <= 1'b0;
            wake_q   <= 1'b0;
            flush_q  <= 1'b0;
            bt_q     <= 1'b0;
        end else begin
            if (!run_i) begin
                active_q <= 1'b0;
                dead_q   <= 1'b0;
            end else if (kill_i) begin
                dead_q   <= 1'b1;
                active_q <= 1'b0;
            end else if (stop_i) begin
                active_q <= 1'b0;
            end else if (start_take_o || (wake_i && !dead_q)) begin
                active_q <= 1'b1;
            end

            if (wake_i && run_i)  wake_q <= 1'b1;
            else if (wake_clr_i)  wake_q <= 1'b0;

            if (flush_i)          flush_q <= 1'b1;
            else if (flush_clr_i) flush_q <= 1'b0;

            if (bt_set_i)      bt_q <= 1'b1;
            else if (bt_clr_i) bt_q <= 1'b0;
        end
    end

    always_comb begin
        stat_o           = '0;
        stat_o[3:0]      = dev_stat_i;
        stat_o[ST_BT]    = bt_q;
        stat_o[ST_ACT]   = active_q;
        stat_o[ST_DEAD]  = dead_q;
        stat_o[ST_WAKE]  = wake_q;
        stat_o[ST_FLUSH] = flush_q;
        stat_o[ST_RUN]   = run_i;
    end

    // R3: a dead channel is never active
    a_r3_dead_not_active: assert property (@(posedge clk) disable iff (!rst_n)
        dead_q |-> !active_q) else $error("dead and active together");

    // R13: dropping run clears active and dead
    a_r13_run_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!active_q && !dead_q)) else $error("run low did not clear");

    // R3: a kill while running leaves the channel dead
    a_r3_kill_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && run_i) |=> (dead_q && !active_q)) else $error("kill ignored");

endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
    import dsq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_ptr_i,
    input  logic              wake_i,
    input  logic              flush_i,
    input  logic [3:0]        dev_stat_i,
    input  logic              cond_wait_i,
    input  logic              cond_irq_i,
    input  logic              cond_br_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [3:0]        mem_be_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              xfer_req_o,
    output logic              xfer_out_o,
    output logic              xfer_last_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [15:0]       xfer_len_o,
    input  logic              xfer_done_i,
    input  logic [15:0]       xfer_resid_i,
    output logic              irq_o,
    output logic [15:0]       stat_o,
    output logic [ADDR_W-1:0] cmd_ptr_o
);
    localparam int NSEL = 3;
    localparam int WORDS_PER_DESC = DESC_BYTES / 4;
    localparam int IDX_W = $clog2(WORDS_PER_DESC);

    dsq_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q;
    logic [15:0]       cmd_q, req_q, resid_q;
    logic [ADDR_W-1:0] addr_q, ptr_q;
    logic [31:0]       dep_q;
    logic              irq_q;

    logic [3:0] op;
    logic [2:0] key;
    logic       is_xfer, is_word, is_last, is_out, kill_cond;
    logic       active, dead;
    logic       start_take, kill, stop, wake_clr, flush_clr, bt_set, bt_clr;
    logic       take_br;
    logic [ADDR_W-1:0] word_addr;
    logic [3:0]        word_be;
    logic [NSEL-1:0][1:0] sel_fld;
    logic [NSEL-1:0]      sel_cond, sel_hit;
    logic wait_hit, irq_hit, br_hit;
    logic unused_bits;

    assign op      = cmd_q[15:12];
    assign key     = cmd_q[10:8];
    assign is_xfer = (op[3:2] == 2'b00);
    assign is_word = (op == OP_STORE_W) || (op == OP_LOAD_W);
    assign is_last = is_xfer & op[0];
    assign is_out  = is_xfer & ~op[1];
    assign kill_cond = op[3]
                     | (is_xfer & ((addr_q == '0) | (32'(key) >= KEY_LIMIT)))
                     | (is_word & (32'(key) >= KEY_LIMIT));
    assign unused_bits = ^{cmd_q[11], cmd_q[7:6], req_q[15:3]};

    // condition selects: wait, interrupt, branch
    assign sel_fld  = {cmd_q[3:2], cmd_q[5:4], cmd_q[1:0]};
    assign sel_cond = {cond_br_i, cond_irq_i, cond_wait_i};
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        dsq_cond_sel u_sel (
            .sel_i  (sel_fld[g]),
            .cond_i (sel_cond[g]),
            .hit_o  (sel_hit[g])
        );
    end
    assign wait_hit = sel_hit[0];
    assign irq_hit  = sel_hit[1];
    assign br_hit   = sel_hit[2];
    assign take_br  = br_hit & ~is_word;

    dsq_word_size #(.ADDR_W(ADDR_W)) u_size (
        .cnt_lo_i (req_q[2:0]),
        .addr_i   (addr_q),
        .addr_o   (word_addr),
        .be_o     (word_be)
    );

    assign active = stat_o[ST_ACT];
    assign dead   = stat_o[ST_DEAD];

    // status strobes
    assign wake_clr  = (state_q == S_IDLE) && run_i && active;
    assign stop      = (state_q == S_DECODE) && (op == OP_STOP);
    assign kill      = (state_q == S_DECODE) && (op != OP_STOP) && kill_cond;
    assign flush_clr = (state_q == S_WB_STAT) && mem_ack_i && (is_last || is_word);
    assign bt_set    = (state_q == S_NEXT) && take_br;
    assign bt_clr    = (state_q == S_NEXT) && !take_br;

    dsq_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .start_i      (start_i),
        .wake_i       (wake_i),
        .flush_i      (flush_i),
        .dev_stat_i   (dev_stat_i),
        .kill_i       (kill),
        .stop_i       (stop),
        .wake_clr_i   (wake_clr),
        .flush_clr_i  (flush_clr),
        .bt_set_i     (bt_set),
        .bt_clr_i     (bt_clr),
        .start_take_o (start_take),
        .stat_o       (stat_o)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (run_i && active) state_d = S_FETCH;
            S_FETCH:   if (mem_ack_i && idx_q == IDX_W'(WORDS_PER_DESC - 1)) state_d = S_DECODE;
            S_DECODE: begin
                if (op == OP_STOP || kill_cond) state_d = S_IDLE;
                else if (op == OP_NOP)          state_d = S_DONE;
                else if (is_xfer)               state_d = S_XFER;
                else                            state_d = S_WORD;
            end
            S_XFER:    if (xfer_done_i) state_d = S_DONE;
            S_WORD:    if (mem_ack_i) state_d = S_DONE;
            S_DONE: begin
                if (wait_hit)              state_d = S_IDLE;
                else if (op == OP_LOAD_W)  state_d = S_WB_DEP;
                else                       state_d = S_WB_STAT;
            end
            S_WB_DEP:  if (mem_ack_i) state_d = S_WB_STAT;
            S_WB_STAT: if (mem_ack_i) state_d = S_NEXT;
            S_NEXT:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = ptr_q;
        mem_be_o    = 4'b1111;
        mem_wdata_o = dep_q;
        unique case (state_q)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr_q + ADDR_W'({idx_q, 2'b00});
            end
            S_WORD: begin
                mem_req_o  = 1'b1;
                mem_we_o   = (op == OP_STORE_W);
                mem_addr_o = word_addr;
                mem_be_o   = word_be;
            end
            S_WB_DEP: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = ptr_q + ADDR_W'(8);
            end
            S_WB_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr_q + ADDR_W'(12);
                mem_be_o    = is_xfer ? 4'b1111 : 4'b1100;
                mem_wdata_o = {stat_o, resid_q};
            end
            default: ;
        endcase
        xfer_req_o  = (state_q == S_XFER);
        xfer_out_o  = is_out;
        xfer_last_o = is_last;
        xfer_addr_o = addr_q;
        xfer_len_o  = req_q;
        irq_o       = irq_q;
        cmd_ptr_o   = ptr_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            cmd_q   <= '0;
            req_q   <= '0;
            addr_q  <= '0;
            dep_q   <= '0;
            resid_q <= '0;
            ptr_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= kill || ((state_q == S_NEXT) && irq_hit);
            if (state_q == S_IDLE) idx_q <= '0;
            if (state_q == S_FETCH && mem_ack_i) begin
                idx_q <= idx_q + 1'b1;
                unique case (idx_q)
                    2'd0: begin
                        req_q <= mem_rdata_i[15:0];
                        cmd_q <= mem_rdata_i[31:16];
                    end
                    2'd1: addr_q <= mem_rdata_i[ADDR_W-1:0];
                    2'd2: dep_q  <= mem_rdata_i;
                    default: ;
                endcase
            end
            if (state_q == S_XFER && xfer_done_i) resid_q <= xfer_resid_i;
            if (state_q == S_WORD && mem_ack_i && op == OP_LOAD_W) begin
                for (int b = 0; b < 4; b++) begin
                    if (word_be[b]) dep_q[8*b +: 8] <= mem_rdata_i[8*b +: 8];
                end
            end
            if (start_take) begin
                ptr_q <= {start_ptr_i[ADDR_W-1:4], 4'b0000};
            end else if (state_q == S_NEXT) begin
                if (take_br) ptr_q <= {dep_q[ADDR_W-1:4], 4'b0000};
                else         ptr_q <= ptr_q + ADDR_W'(DESC_BYTES);
            end
        end
    end

    // R4: the data mover and the memory port are never used together
    a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> !mem_req_o) else $error("mover and memory both busy");

    // R12: stop leaves the pointer where it was
    a_r12_stop_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECODE && op == OP_STOP) |=> $stable(ptr_q)) else $error("stop moved pointer");

    // R9: a sequential step advances by one descriptor and clears branch-taken
    a_r9_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NEXT && !take_br && !start_take) |=>
            (ptr_q == $past(ptr_q) + ADDR_W'(DESC_BYTES)) && !stat_o[ST_BT]) else $error("bad sequential step");

    // R1: fetch starts only from a running, active channel
    a_r1_fetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && state_d == S_FETCH) |-> (run_i && active)) else $error("fetch while stopped");

    // R5: status write-back always covers the status half
    a_r5_wb_be: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WB_STAT) |-> (mem_we_o && mem_be_o[3:2] == 2'b11)) else $error("status not written");

endmodule

// File: tb/tb_dsq_sequencer.sv
`timescale 1ns/1ps
module tb_dsq_sequencer;
    localparam int AW = 32;
    localparam logic [15:0] S_RUNB = 16'h0800, S_ACTB = 16'h0080, S_FLB = 16'h0400;

    logic clk = 0, rst_n = 0;
    logic run_i = 0, start_i = 0, wake_i = 0, flush_i = 0;
    logic [AW-1:0] start_ptr_i = '0;
    logic [3:0] dev_stat_i = '0;
    logic cond_wait_i = 0, cond_irq_i = 0, cond_br_i = 0;
    logic mem_req_o, mem_we_o, mem_ack_i;
    logic [AW-1:0] mem_addr_o;
    logic [3:0] mem_be_o;
    logic [31:0] mem_wdata_o, mem_rdata_i;
    logic xfer_req_o, xfer_out_o, xfer_last_o;
    logic [AW-1:0] xfer_addr_o;
    logic [15:0] xfer_len_o;
    logic xfer_done_i = 0;
    logic [15:0] xfer_resid_i = 16'd5;
    logic irq_o;
    logic [15:0] stat_o;
    logic [AW-1:0] cmd_ptr_o;

    int checks = 0, errors = 0, irq_cnt = 0, mv_cnt = 0;
    logic cap_out, cap_last, seen_wake = 0;
    logic [AW-1:0] cap_addr;
    logic [15:0] cap_len;
    logic [31:0] mem [256];

    always #2 clk = ~clk;

    dsq_sequencer #(.ADDR_W(AW)) dut (.*);

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[(a >> 2) & 255][8*(a & 3) +: 8];
    endfunction

    assign mem_ack_i = mem_req_o;
    always_comb begin
        for (int b = 0; b < 4; b++) mem_rdata_i[8*b +: 8] = rd_byte(mem_addr_o + b);
    end

    always @(posedge clk) begin
        if (mem_req_o && mem_we_o) begin
            for (int b = 0; b < 4; b++) begin
                if (mem_be_o[b]) begin
                    logic [31:0] a;
                    a = mem_addr_o + b;
                    mem[(a >> 2) & 255][8*(a & 3) +: 8] <= mem_wdata_o[8*b +: 8];
                end
            end
        end
        if (irq_o) irq_cnt <= irq_cnt + 1;
        if (stat_o[9]) seen_wake <= 1'b1;
        if (xfer_done_i) begin
            xfer_done_i <= 1'b0;
            mv_cnt <= 0;
        end else if (xfer_req_o) begin
            cap_out <= xfer_out_o; cap_last <= xfer_last_o;
            cap_addr <= xfer_addr_o; cap_len <= xfer_len_o;
            mv_cnt <= mv_cnt + 1;
            if (mv_cnt == 2) xfer_done_i <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int op, input int key, input int irs, input int brs, input int ws);
        return 16'((op << 12) | (key << 8) | (irs << 4) | (brs << 2) | ws);
    endfunction

    task automatic put(input logic [31:0] a, input logic [15:0] cmd, input logic [15:0] req,
                       input logic [31:0] da, input logic [31:0] dep, input logic [31:0] w3);
        mem[(a >> 2) & 255]       = {cmd, req};
        mem[((a >> 2) + 1) & 255] = da;
        mem[((a >> 2) + 2) & 255] = dep;
        mem[((a >> 2) + 3) & 255] = w3;
    endtask

    task automatic start_chain(input logic [31:0] p);
        @(negedge clk) run_i = 0;
        @(negedge clk) begin run_i = 1; start_i = 1; start_ptr_i = p; end
        @(negedge clk) start_i = 0;
    endtask

    task automatic wait_stop();
        for (int k = 0; k < 3000 && stat_o[7]; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_chain(input logic [31:0] p);
        start_chain(p);
        wait_stop();
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        int irq0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R14 reset state
        chk("R14 reset status", 32'(stat_o), 0);
        chk("R1 reset no request", {30'b0, mem_req_o, xfer_req_o}, 0);
        chk("R10 reset irq", 32'(irq_o), 0);

        // R1 R12 R5: two no-ops then stop
        put(32'h100, mk(6,0,0,0,0), 0, 0, 0, 32'h0000BEEF);
        put(32'h110, mk(6,0,0,0,0), 0, 0, 0, 32'h0000BEEF);
        put(32'h120, mk(7,0,0,0,0), 0, 0, 0, 32'h0000BEEF);
        run_chain(32'h10F);
        chk("R12 stop keeps pointer", cmd_ptr_o, 32'h120);
        chk("R5 no-op status write-back", mem[(32'h10C)>>2], {S_RUNB | S_ACTB, 16'hBEEF});
        chk("R12 stop clears active", 32'(stat_o[7]), 0);

        // R9 branch select sweep
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                logic tk;
                tk = (s == 3) || (s == 1 && c == 1) || (s == 2 && c == 0);
                put(32'h100, mk(6,0,0,s,0), 0, 0, 32'h0000_0207, 0);
                put(32'h110, mk(7,0,0,0,0), 0, 0, 0, 0);
                put(32'h200, mk(7,0,0,0,0), 0, 0, 0, 0);
                cond_br_i = c[0];
                run_chain(32'h100);
                chk($sformatf("R9 branch ptr sel=%0d c=%0d", s, c), cmd_ptr_o, tk ? 32'h200 : 32'h110);
                chk($sformatf("R9 branch-taken sel=%0d c=%0d", s, c), 32'(stat_o[6]), 32'(tk));
            end
        end
        cond_br_i = 0;

        // R10 interrupt select sweep
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                logic hit;
                hit = (s == 3) || (s == 1 && c == 1) || (s == 2 && c == 0);
                put(32'h100, mk(6,0,s,0,0), 0, 0, 0, 0);
                put(32'h110, mk(7,0,0,0,0), 0, 0, 0, 0);
                cond_irq_i = c[0];
                irq0 = irq_cnt;
                run_chain(32'h100);
                chk($sformatf("R10 irq count sel=%0d c=%0d", s, c), 32'(irq_cnt - irq0), 32'(hit));
            end
        end
        cond_irq_i = 0;

        // R4 R5 R6 transfers
        @(negedge clk) flush_i = 1;
        @(negedge clk) flush_i = 0;
        put(32'h100, mk(0,0,0,0,0), 16'h0020, 32'h400, 0, 0);
        put(32'h110, mk(7,0,0,0,0), 0, 0, 0, 0);
        run_chain(32'h100);
        chk("R4 output request fields", {cap_out, cap_last, cap_len, cap_addr[13:0]}, {1'b1, 1'b0, 16'h0020, 14'h400});
        chk("R5 transfer residual write-back", mem[(32'h10C)>>2], {S_RUNB | S_ACTB | S_FLB, 16'h0005});
        chk("R6 flush kept after more", 32'(stat_o[10]), 1);
        put(32'h100, mk(3,2,0,0,0), 16'h0010, 32'h440, 0, 0);
        run_chain(32'h100);
        chk("R4 input request fields", {cap_out, cap_last, cap_len, cap_addr[13:0]}, {1'b0, 1'b1, 16'h0010, 14'h440});
        chk("R5 input-last write-back", mem[(32'h10C)>>2], {S_RUNB | S_ACTB | S_FLB, 16'h0005});
        chk("R6 flush cleared after last", 32'(stat_o[10]), 0);

        // R11 wait hold and R13 start ignored while active
        put(32'h100, mk(6,0,0,0,1), 0, 0, 0, 32'h0000BEEF);
        put(32'h110, mk(7,0,0,0,0), 0, 0, 0, 0);
        cond_wait_i = 1;
        start_chain(32'h100);
        repeat (100) @(negedge clk);
        chk("R11 wait keeps pointer", cmd_ptr_o, 32'h100);
        chk("R11 wait skips write-back", mem[(32'h10C)>>2], 32'h0000BEEF);
        chk("R11 channel still active", 32'(stat_o[7]), 1);
        @(negedge clk) begin start_i = 1; start_ptr_i = 32'h300; end
        @(negedge clk) start_i = 0;
        repeat (5) @(negedge clk);
        chk("R13 start ignored while active", cmd_ptr_o, 32'h100);
        cond_wait_i = 0;
        wait_stop();
        chk("R11 retried after release", cmd_ptr_o, 32'h110);
        chk("R11 write-back after release", mem[(32'h10C)>>2], {S_RUNB | S_ACTB, 16'hBEEF});

        // R7 R8 load-word size sweep
        for (int r = 0; r < 8; r++) begin
            logic [31:0] exp;
            if (r & 4)      exp = 32'h44332211;
            else if (r & 2) exp = 32'hAAAA4433;
            else            exp = 32'hAAAAAA44;
            mem[32'h300 >> 2] = 32'h44332211;
            put(32'h100, mk(5,1,0,3,0), 16'(r | 16'h0010), 32'h303, 32'hAAAAAAAA, 0);
            put(32'h110, mk(7,0,0,0,0), 0, 0, 0, 0);
            run_chain(32'h100);
            chk($sformatf("R7 load size req=%0d", r), mem[(32'h108)>>2], exp);
            chk($sformatf("R8 load never branches req=%0d", r), cmd_ptr_o, 32'h110);
        end

        // R8 store-word, 2 bytes at aligned address
        mem[32'h310 >> 2] = 0;
        put(32'h100, mk(4,0,0,0,0), 16'h0002, 32'h311, 32'h88776655, 0);
        put(32'h110, mk(7,0,0,0,0), 0, 0, 0, 0);
        run_chain(32'h100);
        chk("R8 store two bytes", mem[32'h310 >> 2], 32'h00006655);

        // R3 R2 kill cases
        for (int t = 0; t < 4; t++) begin
            logic [15:0] cmd;
            logic [31:0] da;
            case (t)
                0: begin cmd = mk(0,0,0,0,0); da = 0; end
                1: begin cmd = mk(3,4,0,0,0); da = 32'h400; end
                2: begin cmd = mk(5,5,0,0,0); da = 32'h300; end
                default: begin cmd = mk(9,0,0,0,0); da = 32'h400; end
            endcase
            put(32'h100, cmd, 16'h0004, da, 0, 0);
            irq0 = irq_cnt;
            run_chain(32'h100);
            chk($sformatf("R3 kill dead case %0d", t), {stat_o[8], stat_o[7]}, 2'b10);
            chk($sformatf("R3 kill irq case %0d", t), 32'(irq_cnt - irq0), 1);
            if (t == 3) chk("R2 undefined opcode ptr", cmd_ptr_o, 32'h100);
        end
        @(negedge clk) run_i = 0;
        @(negedge clk);
        chk("R13 run low clears dead", 32'(stat_o[8]), 0);

        // R1 R13 wake sets wake and active, fetch clears wake
        put(32'h100, mk(7,0,0,0,0), 0, 0, 0, 0);
        run_chain(32'h100);
        seen_wake = 0;
        @(negedge clk) wake_i = 1;
        @(negedge clk) wake_i = 0;
        repeat (20) @(negedge clk);
        chk("R13 wake bit was set", 32'(seen_wake), 1);
        chk("R1 wake cleared by fetch", {stat_o[9], stat_o[7]}, 0);
        chk("R12 stop after wake keeps ptr", cmd_ptr_o, 32'h100);
        dev_stat_i = 4'hA;
        @(negedge clk);
        chk("R14 device status bits", 32'(stat_o[3:0]), 32'hA);

        finish_sim();
    end
endmodule